// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine

This block turns an oversampled asynchronous serial line into whole characters. A 16x sample enable from an external divisor paces it. The line input passes through a synchronizer. Each start bit is confirmed at its centre, and every later bit is read at its own centre, least significant bit first.

The character length is 5 to 8 data bits. Parity is optional and can be odd, even, forced one or forced zero. The frame ends with one or two stop bits. Each finished character leaves the block as a one-cycle push strobe. The strobe carries the data byte and three error tags: parity, framing and break. A downstream FIFO stores the tags together with their character.

Two line conditions get special handling. A low stop bit is taken to be the start bit of the next frame, and reception continues without waiting for a new falling edge. A line held low for a whole frame gives exactly one zero character tagged as a break, however long the low lasts. After a break, the receiver waits until the line has been high for half a bit time before it looks for a start bit again. If the FIFO reports full when a character completes, the character is dropped and an overrun pulse is raised.

Top module: `uart_rx_core`

## Requirements
- R1: While reset is held and directly after it, `push` and `ovr` are low.
- R2: A falling edge starts a frame only if the line is still low at the eighth sample. A shorter low pulse produces no character.
- R3: Data bits are sampled at bit centre, LSB first. `cfg_dbits` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Bits above the selected length read as zero in `push_data`.
- R4: With `cfg_par_en` set, one parity bit follows the data. `cfg_par_mode` values 0, 1, 2 and 3 select odd, even, always-1 and always-0. `push_perr` is set when the received bit differs from the expected bit.
- R5: A first stop bit sampled low sets `push_ferr`.
- R6: After a framing error that is not a break, the low level is checked once more one sample later. If it is still low, data bits are taken 16 samples after the stop-bit centre, with no new falling edge needed.
- R7: A frame whose start, data, parity and stop samples are all low yields exactly one push with data 0, `push_brk`=1 and `push_ferr`=1, however long the low lasts.
- R8: After a break, a new start is accepted only after 8 consecutive high samples. Any low sample restarts that count.
- R9: If `fifo_full` is high when a character completes, `push` stays low and `ovr` pulses for one cycle instead.
- R10: With `cfg_stop2` set, only the first stop bit is checked. The receiver waits out the second stop bit before looking for a start, so back-to-back frames are received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16x bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_dbits | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 always 1, 3 always 0 |
| cfg_stop2 | input | 1 | Two stop bits |
| fifo_full | input | 1 | Receive FIFO cannot accept a character |
| push | output | 1 | One-cycle character write strobe |
| push_data | output | 8 | Received character, zero above length |
| push_perr | output | 1 | Parity error tag |
| push_ferr | output | 1 | Framing error tag |
| push_brk | output | 1 | Break tag |
| ovr | output | 1 | One-cycle pulse: character dropped |

## Verification
The bench sends a low stop bit followed directly by the data of the next frame. A receiver that waited for a fresh edge after a framing error would lose the second character or shift its bits. A break several frames long is followed by short high glitches. A design that pushed once per frame time would emit extra zero characters, and one without the half-bit exit qualification would decode the glitches as frames. Short false-start pulses, bad parity in every mode, 5-bit masking and a full FIFO are also exercised. Each of these would show up as a wrong tag, a wrong byte, or a push the scoreboard did not expect.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int MAX_BITS = 8;
    localparam int OVS      = 16;
    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR,
        ST_STOP1, ST_STOP2, ST_CONFIRM, ST_BRKW
    } rx_state_e;

    typedef struct packed {
        rx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [MAX_BITS-1:0]  data;
        logic                 par;
        logic                 allz;
        logic                 push;
        logic                 perr;
        logic                 ferr;
        logic                 brk;
        logic                 ovr;
    } rx_regs_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic [1:0]   mode,
    output logic         exp_bit
);
    always_comb begin
        case (mode)
            2'd0:    exp_bit = ~(^data);
            2'd1:    exp_bit = ^data;
            2'd2:    exp_bit = 1'b1;
            default: exp_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_dbits,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop2,
    input  logic       fifo_full,
    output logic       push,
    output logic [7:0] push_data,
    output logic       push_perr,
    output logic       push_ferr,
    output logic       push_brk,
    output logic       ovr
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(MAX_BITS - 4);

    rx_regs_t q, d;
    logic rx_s, exp_par, last_bit, brk_now, ferr_now;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    uart_rx_parity #(.W(MAX_BITS)) i_par (
        .data(q.data), .mode(cfg_par_mode), .exp_bit(exp_par)
    );

    assign last_bit = (q.idx == IDX_BASE + IDX_W'(cfg_dbits));
    assign brk_now  = !rx_s && q.allz;
    assign ferr_now = !rx_s;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        d.ovr  = 1'b0;
        if (tick16) begin
            case (q.st)
                ST_IDLE: begin
                    if (!rx_s) begin
                        d.st  = ST_START;
                        d.cnt = CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (q.cnt == CNT_MID) begin
                        if (!rx_s) begin
                            d.st   = ST_DATA;
                            d.cnt  = '0;
                            d.idx  = '0;
                            d.data = '0;
                            d.allz = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt         = '0;
                        d.data[q.idx] = rx_s;
                        if (rx_s) d.allz = 1'b0;
                        if (last_bit) d.st = cfg_par_en ? ST_PAR : ST_STOP1;
                        else          d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        d.par = rx_s;
                        if (rx_s) d.allz = 1'b0;
                        d.st  = ST_STOP1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP1: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt  = '0;
                        d.brk  = brk_now;
                        d.ferr = ferr_now;
                        d.perr = cfg_par_en && !brk_now && (q.par != exp_par);
                        if (fifo_full) d.ovr  = 1'b1;
                        else           d.push = 1'b1;
                        if (brk_now)        d.st = ST_BRKW;
                        else if (ferr_now)  d.st = ST_CONFIRM;
                        else if (cfg_stop2) d.st = ST_STOP2;
                        else                d.st = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP2: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    if (!rx_s) begin
                        d.st   = ST_DATA;
                        d.cnt  = CNT_W'(1);
                        d.idx  = '0;
                        d.data = '0;
                        d.allz = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                ST_BRKW: begin
                    if (rx_s) begin
                        if (q.cnt == CNT_MID) d.st = ST_IDLE;
                        else                  d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt = '0;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push      = q.push;
    assign push_data = q.data;
    assign push_perr = q.perr;
    assign push_ferr = q.ferr;
    assign push_brk  = q.brk;
    assign ovr       = q.ovr;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_dbits,
    input logic       fifo_full,
    input logic       push,
    input logic [7:0] push_data,
    input logic       push_ferr,
    input logic       push_brk,
    input logic       ovr
);
    always_comb begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!push && !ovr);
        end
    end

    a_r9_push_or_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && ovr));

    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(!fifo_full));

    a_r9_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> $past(fifo_full));

    a_r7_break_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_brk) |-> (push_data == 8'h00 && push_ferr));

    a_r7_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    a_r3_masked_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cfg_dbits == 2'd0) |-> (push_data[7:5] == 3'b000));
endmodule

bind uart_rx_core uart_rx_checker i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_dbits(cfg_dbits), .fifo_full(fifo_full),
    .push(push), .push_data(push_data), .push_ferr(push_ferr),
    .push_brk(push_brk), .ovr(ovr)
);

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_dbits = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       fifo_full = 1'b0;
    logic       push, push_perr, push_ferr, push_brk, ovr;
    logic [7:0] push_data;

    int tests = 0;
    int fails = 0;
    int ovr_seen = 0;
    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_stop2(cfg_stop2),
        .fifo_full(fifo_full), .push(push), .push_data(push_data),
        .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
        .ovr(ovr)
    );

    task automatic expect_item(input logic [7:0] d, input logic pe,
                               input logic fe, input logic bk, input string tag);
        exp_q.push_back({bk, fe, pe, d});
        tag_q.push_back(tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && ovr) ovr_seen++;
        if (rst_n && push) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected push: actual data=%h pe=%b fe=%b brk=%b expected none",
                         push_data, push_perr, push_ferr, push_brk);
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({push_brk, push_ferr, push_perr, push_data} !== e) begin
                    fails++;
                    $display("FAIL %s: actual brk/fe/pe/data=%b/%b/%b/%h expected %b/%b/%b/%h",
                             t, push_brk, push_ferr, push_perr, push_data,
                             e[10], e[9], e[8], e[7:0]);
                end
            end
        end
    end

    function automatic logic par_bit(input logic [7:0] d, input int nb, input logic [1:0] m);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        case (m)
            2'd0: return ~x;
            2'd1: return x;
            2'd2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic bit_out(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int nb, input logic pen, input logic [1:0] pm, input logic s2);
        cfg_dbits = 2'(nb - 5);
        cfg_par_en = pen;
        cfg_par_mode = pm;
        cfg_stop2 = s2;
    endtask

    task automatic frame(input logic [7:0] d, input int nb, input logic bad_par,
                         input logic stop_val);
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(d[i]);
        if (cfg_par_en) bit_out(par_bit(d, nb, cfg_par_mode) ^ bad_par);
        bit_out(stop_val);
        if (cfg_stop2) bit_out(1'b1);
    endtask

    task automatic check(input logic ok, input string msg, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(push === 1'b0 && ovr === 1'b0, "R1 reset outputs", int'(push), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(push === 1'b0 && ovr === 1'b0, "R1 after reset", int'(ovr), 0);
        idle(20);

        // R3: 8N1 and 5-bit masking
        set_cfg(8, 0, 0, 0);
        expect_item(8'hA5, 0, 0, 0, "R3 8-bit A5");
        frame(8'hA5, 8, 0, 1); idle(20);
        set_cfg(5, 0, 0, 0);
        expect_item(8'h15, 0, 0, 0, "R3 5-bit 15");
        frame(8'hF5, 5, 0, 1); idle(20);
        set_cfg(6, 0, 0, 0);
        expect_item(8'h2A, 0, 0, 0, "R3 6-bit 2A");
        frame(8'h2A, 6, 0, 1); idle(20);

        // R4: parity modes
        set_cfg(7, 1, 1, 0);
        expect_item(8'h5B, 0, 0, 0, "R4 even ok");
        frame(8'h5B, 7, 0, 1); idle(20);
        set_cfg(8, 1, 0, 0);
        expect_item(8'h3C, 1, 0, 0, "R4 odd bad");
        frame(8'h3C, 8, 1, 1); idle(20);
        expect_item(8'h81, 0, 0, 0, "R4 odd ok");
        frame(8'h81, 8, 0, 1); idle(20);
        set_cfg(8, 1, 2, 0);
        expect_item(8'h11, 1, 0, 0, "R4 stick1 bad");
        frame(8'h11, 8, 1, 1); idle(20);
        set_cfg(6, 1, 3, 0);
        expect_item(8'h33, 0, 0, 0, "R4 stick0 ok");
        frame(8'h33, 6, 0, 1); idle(20);

        // R2: false start pulse, then valid frame
        set_cfg(8, 0, 0, 0);
        rxd = 1'b0; repeat (5) @(negedge clk);
        idle(40);
        expect_item(8'h69, 0, 0, 0, "R2 frame after false start");
        frame(8'h69, 8, 0, 1); idle(20);

        // R5 + R6: low stop then line high -> resync reads all ones
        expect_item(8'h42, 0, 1, 0, "R5 framing error");
        expect_item(8'hFF, 0, 0, 0, "R6 resync on held low");
        frame(8'h42, 8, 0, 0); idle(200);

        // R6: bad stop is start of the next frame
        expect_item(8'hA5, 0, 1, 0, "R5 back-to-back ferr");
        expect_item(8'h3C, 0, 0, 0, "R6 resync frame");
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(8'hA5 >> i);
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(8'h3C >> i);
        bit_out(1'b1); idle(40);

        // R7 + R8: long break with short high glitches
        expect_item(8'h00, 0, 1, 1, "R7 single break char");
        rxd = 1'b0; repeat (480) @(negedge clk);
        idle(4);
        rxd = 1'b0; repeat (40) @(negedge clk);
        idle(6);
        rxd = 1'b0; repeat (40) @(negedge clk);
        idle(40);
        expect_item(8'h5A, 0, 0, 0, "R8 frame after break exit");
        frame(8'h5A, 8, 0, 1); idle(20);

        // R10: two stop bits, back-to-back
        set_cfg(8, 1, 1, 1);
        expect_item(8'hC3, 0, 0, 0, "R10 first 2-stop");
        expect_item(8'h7E, 0, 0, 0, "R10 second 2-stop");
        frame(8'hC3, 8, 0, 1);
        frame(8'h7E, 8, 0, 1); idle(20);

        // R9: overrun
        set_cfg(8, 0, 0, 0);
        fifo_full = 1'b1;
        ovr_seen = 0;
        frame(8'h99, 8, 0, 1); idle(20);
        check(ovr_seen == 1, "R9 overrun pulses", ovr_seen, 1);
        fifo_full = 1'b0;
        expect_item(8'h24, 0, 0, 0, "R9 after overrun");
        frame(8'h24, 8, 0, 1); idle(40);

        check(exp_q.size() == 0, "R7 no missing or extra chars", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule